// File: doc/BRIEF.md
# HDLC Transmit Framer with Underrun Policy

This block turns a stream of bytes from a transmit FIFO into a serial HDLC bit stream, one bit for each pulse of a bit-enable strobe supplied by the line clocking logic. When the FIFO holds data, a frame starts at the next byte boundary of the idle fill. The framer sends an opening flag, then the bytes least significant bit first, then a 16-bit frame check sequence, then a closing flag. A zero is inserted after any run of five ones in the data and check sequence.

A frame ends normally after a byte tagged as last has been sent. If the FIFO is empty when the next byte is needed, an underrun has occurred and a configuration bit selects what happens. The block either closes the frame cleanly with the check sequence and a flag, or aborts it with a run of ones. The fill sent between frames can be continuous ones or back-to-back flags. The whole output, fill included, can be inverted.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, `line_out` equals `~cfg_invert`, and `fifo_pop` and `underrun_pulse` are 0.
- R2: `line_out` changes only on a clock edge where `bit_en` is 1. Each such edge moves it to the next bit of the stream.
- R3: After five consecutive ones from data or check sequence bits, the next bit emitted is an inserted 0, which carries no data. Flags, abort and fill are never stuffed.
- R4: When the FIFO holds data at the end of a fill byte, a frame begins with the flag 0x7E. In time order its bits are 0,1,1,1,1,1,1,0.
- R5: Data bytes are popped one at a time, each at the end of the previous byte or flag, and sent LSB first. After a byte with `fifo_last`=1, the check sequence and a closing flag follow, and every pushed byte is consumed.
- R6: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (0x8408), with register preset 0xFFFF. It is sent as its ones-complement, LSB first. A receiver running the same CRC over data plus check sequence ends at 0xF0B8.
- R7: If the FIFO is empty when a byte is needed and the current byte was not tagged last, `underrun_pulse` is 1 for exactly one cycle. With `cfg_underrun_close`=1 the frame is completed with the check sequence and a closing flag.
- R8: With `cfg_underrun_close`=0 an underrun sends eight ones, with no zero insertion, and then returns to fill. No valid frame is delivered.
- R9: Between frames, `cfg_fill_flags`=0 sends continuous ones and `cfg_fill_flags`=1 sends repeated 0x7E flags.
- R10: With `cfg_invert`=1 every emitted bit is complemented, including flags, abort and fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe: emit the next line bit |
| cfg_fill_flags | input | 1 | 1: flags between frames, 0: ones |
| cfg_invert | input | 1 | Complement every output bit |
| cfg_underrun_close | input | 1 | 1: close frame on underrun, 0: abort |
| fifo_valid | input | 1 | FIFO holds a byte (first-word fall-through) |
| fifo_data | input | 8 | Byte at FIFO head |
| fifo_last | input | 1 | Head byte ends the frame |
| fifo_pop | output | 1 | Consume FIFO head this cycle |
| line_out | output | 1 | Serial HDLC output |
| underrun_pulse | output | 1 | One-cycle pulse when the underrun policy runs |

## Verification
Two functions can collide on the same bit strobe. Zero insertion can fall on the strobe where data hands over to the check sequence or the check sequence hands over to the closing flag. Underrun detection always coincides with the final data bit entering the CRC. The bench provokes the first with all-ones bytes and the second by starving the FIFO after two bytes whose bit pattern ends a long run of ones. It judges both by decoding the line with an independent receiver: destuffing, flag and abort detection, and a CRC residue check, under every combination of fill, inversion and underrun policy.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int FCS_W  = 16;
    localparam logic [BYTE_W-1:0] FLAG_PATTERN  = 8'h7E;
    localparam logic [FCS_W-1:0]  FCS_PRESET    = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY_REFL = 16'h8408;

    typedef enum logic [2:0] {
        ST_FILL, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic value;
        logic stuffable;
    } line_bit_t;

    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
        fcs_step = (c >> 1) ^ ((c[0] ^ b) ? FCS_POLY_REFL : '0);
    endfunction
endpackage

// File: rtl/hdlc_fcs_acc.sv
module hdlc_fcs_acc
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [FCS_W-1:0] fcs_q,
    output logic [FCS_W-1:0] fcs_d
);
    assign fcs_d = en ? fcs_step(fcs_q, bit_in) : fcs_q;

    always_ff @(posedge clk) begin
        if (rst || clr) fcs_q <= FCS_PRESET;
        else            fcs_q <= fcs_d;
    end

    // R6: a clear always restores the preset on the next cycle
    p_fcs_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fcs_q == FCS_PRESET));
endmodule

// File: rtl/hdlc_zero_stuff.sv
module hdlc_zero_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic raw_bit,
    input  logic stuffable,
    output logic stuff_now
);
    localparam int RC_W = $clog2(RUN + 1);
    localparam logic [RC_W-1:0] RUN_MAX = RC_W'(RUN);

    logic [RC_W-1:0] run_q;

    assign stuff_now = (run_q == RUN_MAX);

    always_ff @(posedge clk) begin
        if (rst)                        run_q <= '0;
        else if (bit_en) begin
            if (stuff_now || !stuffable) run_q <= '0;
            else if (raw_bit)            run_q <= run_q + 1'b1;
            else                         run_q <= '0;
        end
    end

    // R3: the ones run never exceeds the stuffing threshold
    p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_MAX);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN  = 5,
    parameter int ABORT_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              cfg_fill_flags,
    input  logic              cfg_invert,
    input  logic              cfg_underrun_close,
    input  logic              fifo_valid,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    output logic              line_out,
    output logic              underrun_pulse
);
    localparam int SEQ_MAX = (ABORT_BITS > FCS_W) ? ABORT_BITS : FCS_W;
    localparam int CNT_W   = $clog2(SEQ_MAX);
    localparam int BI_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BYTE_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_FCS_BIT   = CNT_W'(FCS_W - 1);
    localparam logic [CNT_W-1:0] LAST_ABORT_BIT = CNT_W'(ABORT_BITS - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [FCS_W-1:0]  sreg_q, sreg_d;
    logic              last_q, last_d;
    logic              und_d, take_next, advance, stuff_now;
    logic              fcs_clr, fcs_en;
    logic [FCS_W-1:0]  fcs_q, fcs_d;
    line_bit_t         cur;

    // raw bit for the current position of the sequence
    always_comb begin
        cur = '{value: 1'b1, stuffable: 1'b0};
        unique case (state_q)
            ST_FILL:  cur.value = cfg_fill_flags ? FLAG_PATTERN[cnt_q[BI_W-1:0]] : 1'b1;
            ST_OPEN,
            ST_CLOSE: cur.value = FLAG_PATTERN[cnt_q[BI_W-1:0]];
            ST_DATA,
            ST_FCS:   cur = '{value: sreg_q[0], stuffable: 1'b1};
            default:  cur.value = 1'b1;
        endcase
    end

    hdlc_zero_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .raw_bit(cur.value), .stuffable(cur.stuffable), .stuff_now(stuff_now)
    );

    assign advance = bit_en && !stuff_now;
    assign fcs_en  = advance && (state_q == ST_DATA);

    hdlc_fcs_acc u_fcs (
        .clk(clk), .rst(rst), .clr(fcs_clr), .en(fcs_en),
        .bit_in(sreg_q[0]), .fcs_q(fcs_q), .fcs_d(fcs_d)
    );

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        sreg_d    = sreg_q;
        last_d    = last_q;
        fifo_pop  = 1'b0;
        und_d     = 1'b0;
        fcs_clr   = 1'b0;
        take_next = 1'b0;
        if (advance) begin
            cnt_d = cnt_q + 1'b1;
            unique case (state_q)
                ST_FILL: if (cnt_q == LAST_BYTE_BIT) begin
                    cnt_d = '0;
                    if (fifo_valid) begin
                        state_d = ST_OPEN;
                        fcs_clr = 1'b1;
                    end
                end
                ST_OPEN: if (cnt_q == LAST_BYTE_BIT) begin
                    cnt_d     = '0;
                    take_next = 1'b1;
                end
                ST_DATA: begin
                    sreg_d = sreg_q >> 1;
                    if (cnt_q == LAST_BYTE_BIT) begin
                        cnt_d = '0;
                        if (last_q) begin
                            state_d = ST_FCS;
                            sreg_d  = ~fcs_d;
                        end else begin
                            take_next = 1'b1;
                        end
                    end
                end
                ST_FCS: begin
                    sreg_d = sreg_q >> 1;
                    if (cnt_q == LAST_FCS_BIT) begin
                        cnt_d   = '0;
                        state_d = ST_CLOSE;
                    end
                end
                ST_CLOSE: if (cnt_q == LAST_BYTE_BIT) begin
                    cnt_d   = '0;
                    state_d = ST_FILL;
                end
                ST_ABORT: if (cnt_q == LAST_ABORT_BIT) begin
                    cnt_d   = '0;
                    state_d = ST_FILL;
                end
                default: begin
                    cnt_d   = '0;
                    state_d = ST_FILL;
                end
            endcase
            if (take_next) begin
                if (fifo_valid) begin
                    fifo_pop = 1'b1;
                    sreg_d   = {{(FCS_W-BYTE_W){1'b0}}, fifo_data};
                    last_d   = fifo_last;
                    state_d  = ST_DATA;
                end else begin
                    und_d = 1'b1;
                    if (cfg_underrun_close) begin
                        state_d = ST_FCS;
                        sreg_d  = ~fcs_d;
                    end else begin
                        state_d = ST_ABORT;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_FILL;
            cnt_q          <= '0;
            sreg_q         <= '0;
            last_q         <= 1'b0;
            line_out       <= ~cfg_invert;
            underrun_pulse <= 1'b0;
        end else begin
            state_q        <= state_d;
            cnt_q          <= cnt_d;
            sreg_q         <= sreg_d;
            last_q         <= last_d;
            underrun_pulse <= und_d;
            if (bit_en) line_out <= (stuff_now ? 1'b0 : cur.value) ^ cfg_invert;
        end
    end

    // R2: no strobe, no change on the line
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_out));
    // R3: an inserted bit appears on the line as a space
    p_stuffed_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_en && stuff_now) |=> (line_out == $past(cfg_invert)));
    // R5: bytes leave the FIFO only at a flag or byte boundary
    p_pop_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> ((state_q == ST_OPEN || state_q == ST_DATA) && bit_en));
    // R6: accumulator sits at preset through the whole opening flag
    p_fcs_preset_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN) |-> (fcs_q == FCS_PRESET));
    // R7: underrun pulse lasts one cycle and leaves FCS or abort running
    p_underrun_single_r7: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |=> !underrun_pulse);
    p_underrun_path_r7: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |-> (state_q == ST_FCS || state_q == ST_ABORT));
    // R8: abort bits are marks on the line
    p_abort_marks_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_en && state_q == ST_ABORT && !stuff_now) |=> (line_out != $past(cfg_invert)));
endmodule

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic cfg_fill_flags = 1'b0, cfg_invert = 1'b0, cfg_underrun_close = 1'b0;
    logic [7:0] qdata [0:63];
    logic       qlast [0:63];
    int wr = 0;
    int rd = 0;
    logic fifo_valid, fifo_last, fifo_pop, line_out, underrun_pulse;
    logic [7:0] fifo_data;

    assign fifo_valid = (rd < wr);
    assign fifo_data  = qdata[rd[5:0]];
    assign fifo_last  = qlast[rd[5:0]];

    hdlc_tx_framer dut (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .cfg_fill_flags(cfg_fill_flags), .cfg_invert(cfg_invert),
        .cfg_underrun_close(cfg_underrun_close),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_pop(fifo_pop), .line_out(line_out), .underrun_pulse(underrun_pulse)
    );

    always @(posedge clk) begin
        if (rst) rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    int checks = 0, errors = 0;
    bit done = 0;

    // independent receiver state
    int ones, blen, flags, frames, aborts, badlen, und_cnt, unstable, rx_n;
    bit in_frame, rx_crc_ok, prev_line;
    bit rxbits [0:1023];
    logic [7:0] rx_bytes [0:127];
    logic [7:0] expd [0:63];

    task automatic deliver(input int n);
        logic [15:0] c;
        logic [7:0] b;
        if (n % 8 != 0) begin
            badlen++;
        end else begin
            c = 16'hFFFF;
            for (int i = 0; i < n / 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    b[j] = rxbits[i*8+j];
                    c = (c >> 1) ^ ((c[0] ^ rxbits[i*8+j]) ? 16'h8408 : 16'h0000);
                end
                rx_bytes[i[6:0]] = b;
            end
            rx_n = n / 8 - 2;
            rx_crc_ok = (c == 16'hF0B8);
            frames++;
        end
    endtask

    task automatic rx_bit(input bit v);
        if (v) begin
            ones++;
            if (ones == 7) begin
                if (in_frame && blen > 7) aborts++;
                in_frame = 0;
                blen = 0;
            end else if (in_frame && blen < 1024) begin
                rxbits[blen] = 1'b1;
                blen++;
            end
        end else begin
            if (ones == 6) begin
                flags++;
                if (in_frame && blen - 7 > 0) deliver(blen - 7);
                in_frame = 1;
                blen = 0;
            end else if (ones == 5) begin
                // inserted zero, dropped
            end else if (in_frame && blen < 1024) begin
                rxbits[blen] = 1'b0;
                blen++;
            end
            ones = 0;
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            ones = 0; blen = 0; flags = 0; frames = 0; aborts = 0; badlen = 0;
            und_cnt = 0; unstable = 0; rx_n = 0; in_frame = 0; rx_crc_ok = 0;
            prev_line = line_out;
            bit_en <= 1'b0;
        end else begin
            if (underrun_pulse) und_cnt++;
            if (bit_en) rx_bit(line_out ^ cfg_invert);
            else if (line_out !== prev_line) unstable++;
            prev_line = line_out;
            bit_en <= ~bit_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        qdata[wr[5:0]] = d;
        qlast[wr[5:0]] = l;
        wr = wr + 1;
    endtask

    task automatic wait_frames(input int t);
        for (int k = 0; k < 2000 && frames < t; k++) @(negedge clk);
    endtask

    task automatic check_bytes(input int n, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) if (rx_bytes[i[6:0]] !== expd[i[5:0]]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin
            int len, f0, u0, base;
            cfg_fill_flags     = c[0];
            cfg_invert         = c[1];
            cfg_underrun_close = c[2];
            rst = 1'b1;
            wr = 0;
            repeat (4) @(negedge clk);
            // R1: state under reset
            chk(line_out == ~cfg_invert && !fifo_pop && !underrun_pulse,
                "R1 reset outputs", int'(line_out), int'(~cfg_invert));
            rst = 1'b0;

            // frame A: mixed bytes, including a flag-valued and an all-ones byte
            len = c % 4 + 1;
            for (int i = 0; i < len; i++) begin
                expd[i] = (i == 0) ? 8'hFF : (i == 1) ? 8'h7E : (8'h5A ^ 8'(i * 37) ^ 8'(c));
                push(expd[i], i == len - 1);
            end
            wait_frames(1);
            chk(frames == 1, "R4/R5 frame A delivered", frames, 1);
            chk(rx_crc_ok, "R6 frame A CRC residue", int'(rx_crc_ok), 1);
            chk(rx_n == len, "R5 frame A length", rx_n, len);
            check_bytes(len, "R5 frame A bytes");

            // frame B: all ones, heavy zero insertion
            for (int i = 0; i < 3; i++) begin
                expd[i] = 8'hFF;
                push(8'hFF, i == 2);
            end
            wait_frames(2);
            chk(frames == 2 && rx_crc_ok && rx_n == 3 && badlen == 0,
                "R3 all-ones frame decode", rx_n, 3);
            check_bytes(3, "R3 all-ones bytes");

            // underrun after two bytes with no last tag
            u0 = und_cnt;
            f0 = frames;
            expd[0] = 8'hF0;
            expd[1] = 8'h0F;
            push(8'hF0, 1'b0);
            push(8'h0F, 1'b0);
            repeat (600) @(negedge clk);
            chk(und_cnt - u0 == 1, "R7 underrun pulse count", und_cnt - u0, 1);
            if (cfg_underrun_close) begin
                chk(frames == f0 + 1 && rx_crc_ok && rx_n == 2,
                    "R7 underrun closes frame", frames - f0, 1);
                check_bytes(2, "R7 underrun frame bytes");
            end else begin
                chk(aborts == 1 && frames == f0, "R8 underrun aborts frame", aborts, 1);
            end
            chk(rd == wr, "R5 all bytes consumed", rd, wr);

            // idle fill
            repeat (200) @(negedge clk);
            base = cfg_underrun_close ? 6 : 5;
            if (cfg_fill_flags)
                chk(flags >= base + 10, "R9/R10 flag fill", flags, base + 10);
            else begin
                chk(flags == base, "R9/R10 ones fill flag count", flags, base);
                chk(line_out == ~cfg_invert, "R10 idle mark level", int'(line_out), int'(~cfg_invert));
            end
            chk(unstable == 0, "R2 line steady without strobe", unstable, 0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule